// File: doc/BRIEF.md
# I2C Write-Only Register Target

This block is a synchronous target on a two-wire serial bus. It answers one fixed 7-bit device address and gives the bus controller write access to a bank of 8-bit registers. The system clock oversamples the clock and data lines. The block finds the start, repeated-start and stop conditions, shifts in bytes most significant bit first, and pulls the data line low to acknowledge. It never drives the line high.

After its address and a write direction bit, the block treats the first byte as a command byte and loads it into an internal register pointer. Each data byte after that is written to the register the pointer selects, and the pointer then steps by one. A burst of data bytes therefore fills consecutive registers, wrapping at the top of the pointer range. The register bank sits outside this block. It sees a one-cycle write strobe together with a register address and a data byte.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is held and in the first cycle after it, the acknowledge drive (`sdaDriveLow`) and the write strobe (`wrEn`) are both 0.
- R2: A start condition (data falls while the clock is high), followed by the byte 0xC8, is acknowledged. That byte is address 7'b1100100 in bits 7..1 with a direction bit of 0 in bit 0. Acknowledged means the data line is low while the clock is high on the ninth clock.
- R3: Any other first byte is not acknowledged. This includes the matching address with direction bit 1. The block then leaves the line released and writes nothing until the next start or stop.
- R4: The byte after an acknowledged address is acknowledged and loaded into the register pointer. It causes no write.
- R5: Each later data byte is acknowledged and gives exactly one `wrEn` pulse of one cycle. That pulse carries `wrData` equal to the byte and `wrAddr` equal to the pointer.
- R6: Within one transfer, each data byte after the first is written to the previous address plus one, modulo 2^PTR_W (0xFF is followed by 0x00).
- R7: A stop condition (data rises while the clock is high) ends the transfer. Clocked bytes that follow without a new start get no acknowledge and cause no write.
- R8: A repeated start, given without a stop in between, restarts the address phase exactly like a start.
- R9: Bytes are assembled most significant bit first. The data line is sampled on rising clock edges.
- R10: `sdaDriveLow` changes only while the bus clock is low. It is asserted only in acknowledge slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| wrEn | output | 1 | One-cycle register write strobe |
| wrAddr | output | PTR_W | Register address for the write |
| wrData | output | 8 | Register data for the write |

## Verification
The assertions assume that the bus controller changes the data line only while the clock is low, except to form a start or a stop. They also assume that each bus clock phase lasts well beyond the three-flop synchroniser delay. Under those two conditions an acknowledge drive change always lands inside a low phase, and raw start or stop edges always come before the synchronised response. The bench drives the bus at 8 system clocks per clock phase and places data changes in the middle of each low phase. It models the line as the controller's value ANDed with the release of the target's drive, so acknowledges are read back from the shared wire.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int DATA_BITS = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic loadPtr;
    logic writeByte;
  } dpStrobe_t;

  // Bus events decoded in the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } busEvent_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_DATA,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         stb,
  output busEvent_t         evt,
  output logic [7:0]        rxByte,
  output logic              wrEn,
  output logic [PTR_W-1:0]  wrAddr,
  output logic [7:0]        wrData
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic [PTR_W-1:0] regPtr;

  // Two-flop (or deeper) synchroniser, idle-high reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[TOP-1:0], sclIn};
      sdaPipe <= {sdaPipe[TOP-1:0], sdaIn};
      sclPrev <= sclPipe[TOP];
      sdaPrev <= sdaPipe[TOP];
    end
  end

  assign sclNow = sclPipe[TOP];
  assign sdaNow = sdaPipe[TOP];

  always_comb begin
    evt.sclRise   = sclNow & ~sclPrev;
    evt.sclFall   = ~sclNow & sclPrev;
    evt.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  end

  // Shift register, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (stb.shiftEn) begin
      rxByte <= {rxByte[6:0], sdaNow};
    end
  end

  // Pointer and write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPtr <= '0;
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= stb.writeByte;
      if (stb.loadPtr) begin
        regPtr <= rxByte[PTR_W-1:0];
      end else if (stb.writeByte) begin
        wrAddr <= regPtr;
        wrData <= rxByte;
        regPtr <= regPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1100100
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvent_t  evt,
  input  logic [7:0] rxByte,
  output dpStrobe_t  stb,
  output logic       sdaDriveLow
);

  localparam logic [3:0] LAST_BIT = 4'(DATA_BITS);

  phase_t     phase;
  logic [3:0] bitCnt;
  logic       inAck;
  logic       active;
  logic       byteDone;
  logic       addrHit;
  logic       wantAck;
  phase_t     nextPhase;

  always_comb begin
    active   = (phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_DATA);
    addrHit  = (rxByte[7:1] == DEV_ADDR) && !rxByte[0];
    wantAck  = (phase == PH_ADDR) ? addrHit : 1'b1;
    byteDone = active && !inAck && evt.sclFall && (bitCnt == LAST_BIT);

    stb.shiftEn   = active && !inAck && evt.sclRise && (bitCnt < LAST_BIT);
    stb.loadPtr   = byteDone && (phase == PH_CMD);
    stb.writeByte = byteDone && (phase == PH_DATA);

    unique case (phase)
      PH_ADDR: nextPhase = PH_CMD;
      PH_CMD:  nextPhase = PH_DATA;
      default: nextPhase = phase;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      bitCnt      <= '0;
      inAck       <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (evt.startSeen) begin
      phase       <= PH_ADDR;
      bitCnt      <= '0;
      inAck       <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (evt.stopSeen) begin
      phase       <= PH_IDLE;
      bitCnt      <= '0;
      inAck       <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (active) begin
      if (stb.shiftEn) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (byteDone) begin
        if (wantAck) begin
          inAck       <= 1'b1;
          sdaDriveLow <= 1'b1;
        end else begin
          phase <= PH_SKIP;
        end
      end else if (inAck && evt.sclFall) begin
        inAck       <= 1'b0;
        sdaDriveLow <= 1'b0;
        bitCnt      <= '0;
        phase       <= nextPhase;
      end
    end
  end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1100100,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDriveLow,
  output logic             wrEn,
  output logic [PTR_W-1:0] wrAddr,
  output logic [7:0]       wrData
);

  dpStrobe_t  stb;
  busEvent_t  evt;
  logic [7:0] rxByte;

  i2c_tgt_dp #(
    .PTR_W(PTR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .stb(stb),
    .evt(evt),
    .rxByte(rxByte),
    .wrEn(wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData)
  );

  i2c_tgt_ctrl #(
    .DEV_ADDR(DEV_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .evt(evt),
    .rxByte(rxByte),
    .stb(stb),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaIn,
  input logic             sdaDriveLow,
  input logic             wrEn,
  input logic [PTR_W-1:0] wrAddr
);

  logic             sclQ, sdaQ;
  logic             haveLast;
  logic [PTR_W-1:0] lastAddr;
  logic             busEdge;

  assign busEdge = sclIn && sclQ && (sdaIn != sdaQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      haveLast <= 1'b0;
      lastAddr <= '0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (busEdge) begin
        haveLast <= 1'b0;
      end else if (wrEn) begin
        haveLast <= 1'b1;
        lastAddr <= wrAddr;
      end
    end
  end

  // R1: outputs quiet after a reset cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!wrEn && !sdaDriveLow));

  // R5: a write happens only on an acknowledged byte
  p_write_acked_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> sdaDriveLow);

  // R5: strobe is a single-cycle pulse
  p_write_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R6: consecutive writes in one transfer step by one
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && haveLast) |-> (wrAddr == PTR_W'(lastAddr + 1'b1)));

  // R10: drive changes only while the bus clock is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .sclIn(sclIn),
  .sdaIn(sdaIn),
  .sdaDriveLow(sdaDriveLow),
  .wrEn(wrEn),
  .wrAddr(wrAddr)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 4;
  localparam int PTR_W      = 8;
  localparam logic [6:0] MY_ADDR = 7'b1100100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaDriveLow;
  logic wrEn;
  logic [PTR_W-1:0] wrAddr;
  logic [7:0] wrData;

  int nChecks = 0;
  int nFail = 0;
  int capN = 0;
  int dirtyDrive = 0;
  logic [7:0] capAddr [0:63];
  logic [7:0] capData [0:63];
  logic prevDrive = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaLine = sdaM & ~sdaDriveLow;

  i2c_reg_target #(.DEV_ADDR(MY_ADDR), .PTR_W(PTR_W), .SYNC_STAGES(2)) i_i2c_reg_target (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclM),
    .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow),
    .wrEn(wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData)
  );

  // Write capture and drive-timing monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (wrEn && capN < 64) begin
        capAddr[capN] = wrAddr;
        capData[capN] = wrData;
        capN = capN + 1;
      end
      if (sdaDriveLow !== prevDrive && sclM) dirtyDrive = dirtyDrive + 1;
    end
    prevDrive = sdaDriveLow;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(QTR);
    sclM = 1'b1; waitClk(QTR);
    sdaM = 1'b0; waitClk(QTR);
    sclM = 1'b0; waitClk(QTR);
  endtask

  task automatic busStop();
    sclM = 1'b0; waitClk(QTR);
    sdaM = 1'b0; waitClk(QTR);
    sclM = 1'b1; waitClk(QTR);
    sdaM = 1'b1; waitClk(QTR);
  endtask

  task automatic sendBit(input logic b);
    sclM = 1'b0; waitClk(QTR);
    sdaM = b;    waitClk(QTR);
    sclM = 1'b1; waitClk(2*QTR);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    waitClk(QTR);
    sdaM = 1'b1; waitClk(QTR);
    sclM = 1'b1; waitClk(QTR);
    ack = ~sdaLine;
    waitClk(QTR);
    sclM = 1'b0;
  endtask

  function automatic logic [7:0] patByte(input int cmd, input int i);
    return 8'((cmd * 3 + i * 29 + 8'h5A) & 8'hFF);
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 195000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    logic ack;
    int base;
    int cmds [5] = '{0, 5, 8'h7F, 8'hFD, 8'hA0};

    // R1: reset state
    waitClk(3);
    check(sdaDriveLow == 1'b0 && wrEn == 1'b0, "R1 reset outputs", {sdaDriveLow, wrEn}, 0);
    rstN = 1'b1;
    waitClk(1);
    check(sdaDriveLow == 1'b0 && wrEn == 1'b0, "R1 after release", {sdaDriveLow, wrEn}, 0);
    waitClk(4);

    // R2 R3 R4: sweep all addresses and direction bits
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        logic hit;
        logic ack2;
        hit = (a == int'(MY_ADDR)) && (rw == 0);
        busStart();
        sendByte({7'(a), 1'(rw)}, ack);
        sendByte(8'h33, ack2);
        busStop();
        check(ack == hit, hit ? "R2 address ack" : "R3 address no-ack", ack, hit);
        check(ack2 == hit, hit ? "R4 command ack" : "R3 later byte ignored", ack2, hit);
      end
    end
    check(capN == 0, "R3 R4 no writes in sweep", capN, 0);

    // R5 R6 R9: bursts including pointer wrap
    for (int k = 0; k < 5; k++) begin
      base = capN;
      busStart();
      sendByte({MY_ADDR, 1'b0}, ack);
      check(ack == 1'b1, "R2 burst address", ack, 1);
      sendByte(8'(cmds[k]), ack);
      check(ack == 1'b1, "R4 burst command", ack, 1);
      for (int i = 0; i <= k; i++) begin
        sendByte(patByte(cmds[k], i), ack);
        check(ack == 1'b1, "R5 data ack", ack, 1);
      end
      busStop();
      check(capN - base == k + 1, "R5 write count", capN - base, k + 1);
      for (int i = 0; i <= k; i++) begin
        check(capAddr[base + i] == 8'((cmds[k] + i) & 8'hFF), "R6 write address",
              capAddr[base + i], (cmds[k] + i) & 8'hFF);
        check(capData[base + i] == patByte(cmds[k], i), "R9 write data MSB first",
              capData[base + i], patByte(cmds[k], i));
      end
    end

    // R8: repeated start restarts address phase
    base = capN;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'h10, ack);
    sendByte(8'hC3, ack);
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    check(ack == 1'b1, "R8 address after repeated start", ack, 1);
    sendByte(8'h20, ack);
    sendByte(8'h3C, ack);
    sendByte(8'h81, ack);
    busStop();
    check(capN - base == 3, "R8 write count", capN - base, 3);
    check(capAddr[base] == 8'h10 && capData[base] == 8'hC3, "R8 first write",
          {capAddr[base], capData[base]}, 16'h10C3);
    check(capAddr[base+1] == 8'h20 && capData[base+1] == 8'h3C, "R8 pointer reloaded",
          {capAddr[base+1], capData[base+1]}, 16'h203C);
    check(capAddr[base+2] == 8'h21 && capData[base+2] == 8'h81, "R6 step after reload",
          {capAddr[base+2], capData[base+2]}, 16'h2181);

    // R7: bytes after stop are ignored
    base = capN;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'h40, ack);
    sendByte(8'h11, ack);
    busStop();
    sendByte(8'h22, ack);
    check(ack == 1'b0, "R7 byte after stop", ack, 0);
    sendByte({MY_ADDR, 1'b0}, ack);
    check(ack == 1'b0, "R7 address without start", ack, 0);
    busStop();
    check(capN - base == 1, "R7 write count", capN - base, 1);

    // R3: mismatched address then data
    base = capN;
    busStart();
    sendByte(8'hCC, ack);
    check(ack == 1'b0, "R3 wrong address", ack, 0);
    sendByte(8'h12, ack);
    check(ack == 1'b0, "R3 skipped byte", ack, 0);
    sendByte(8'h34, ack);
    check(ack == 1'b0, "R3 skipped byte 2", ack, 0);
    busStop();
    check(capN - base == 0, "R3 no write", capN - base, 0);

    // R10: drive never changed with clock high
    check(dirtyDrive == 0, "R10 drive timing", dirtyDrive, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule